// File: doc/BRIEF.md
# Arithmetic Right Shifter with Carry and Condition Flags

This execution unit sits in the integer pipeline of a 32-bit processor. It shifts a source word arithmetically to the right by a count taken from a second register operand. Bits that leave the low end are discarded, and the freed high positions are filled with copies of the source sign bit. Under big-endian numbering the sign bit is bit 0, which is the most-significant bit. Alongside the shifted word, the unit produces a carry flag for the fixed-point exception register. The carry is set when a negative source loses at least one 1 bit.

An issue stage presents one operation per cycle with a valid strobe. Every operation updates the result and the carry. When the record-select input is high, the unit also computes a four-bit condition field from the result and raises a write strobe for that field. When record-select is low, the condition field keeps its previous value and no write strobe is raised. All outputs are registered and appear one clock after the valid input.

Top module: `sra_flag_unit`

## Requirements
- R1: On a valid operation, `resultWord` equals `srcWord` shifted right arithmetically by the unsigned value of `amtWord[5:0]`. Bits 31..6 of `amtWord` have no effect.
- R2: A count from 32 to 63 gives a result in which every bit is a copy of `srcWord[31]`, so the result is 0xFFFFFFFF or 0x00000000.
- R3: `carryOut` is 1 when `srcWord[31]` is 1 and at least one 1 bit was shifted out. In every other case `carryOut` is 0. A count of 32 or more counts every source bit as shifted out.
- R4: When `recordMode` is 1, `crField` is loaded as bit3=LT, bit2=GT, bit1=EQ and bit0=SO. LT, GT and EQ come from a signed comparison of the result against zero, and SO is a copy of `soIn`. `crWrite` is 1 in the same cycle.
- R5: When `recordMode` is 0, `crField` keeps its previous value and `crWrite` is 0. `carryOut` and `resultWord` are still updated.
- R6: `outValid` is 1 exactly one clock after `inValid` was 1. While `inValid` is 0, `resultWord` and `carryOut` hold their values.
- R7: After reset, `outValid`, `crWrite`, `carryOut`, `resultWord` and `crField` are all 0.
- R8: Shifting 0x87654321 by 7 gives 0xFF0ECA86 with `carryOut` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| srcWord | input | 32 | Word to shift |
| amtWord | input | 32 | Count operand; only the low 6 bits are used |
| recordMode | input | 1 | 1 = also produce the condition field |
| soIn | input | 1 | Current summary-overflow bit |
| outValid | output | 1 | Registered result is new |
| resultWord | output | 32 | Shifted word |
| carryOut | output | 1 | Carry flag |
| crField | output | 4 | Condition field {LT,GT,EQ,SO} |
| crWrite | output | 1 | Condition field was written this cycle |

## Verification
The bench builds the unit with DATA_W = 32 and USE_BARREL = 1, so the shift is the staged barrel variant, not the language shift operator. At this width the count has six bits. The sixth bit is the one that selects saturation to the sign, so counts of 32 through 63, and operands with junk in their upper bits, reach that path. A bit-by-bit reference model in the bench computes the expected result, carry and condition field for every vector.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef struct packed {
    logic loadRes;
    logic loadCr;
  } ctrlStrobes_t;

  localparam int CR_W = 4;
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         recordMode,
  output ctrlStrobes_t strobes,
  output logic         outValid,
  output logic         crWrite
);
  // load strobes are issued in the cycle the operation arrives
  always_comb begin
    strobes.loadRes = inValid;
    strobes.loadCr  = inValid & recordMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      crWrite  <= 1'b0;
    end else begin
      outValid <= strobes.loadRes;
      crWrite  <= strobes.loadCr;
    end
  end
endmodule

// File: rtl/sra_datapath.sv
module sra_datapath
  import sra_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit USE_BARREL = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] amtWord,
  input  logic              soIn,
  output logic [DATA_W-1:0] resultWord,
  output logic              carryOut,
  output logic [CR_W-1:0]   crField
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int CNT_W = LOG_W + 1;

  logic [CNT_W-1:0]  amt;
  logic              signBit;
  logic              overRange;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] lostMask;
  logic              carryNext;
  logic [CR_W-1:0]   crNext;

  assign amt       = amtWord[CNT_W-1:0];
  assign signBit   = srcWord[DATA_W-1];
  assign overRange = amt[CNT_W-1];

  generate
    if (USE_BARREL) begin : g_barrel
      logic [DATA_W-1:0] stage [LOG_W+1];
      assign stage[0] = srcWord;
      for (genvar k = 0; k < LOG_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
          ? {{STEP{signBit}}, stage[k][DATA_W-1:STEP]}
          : stage[k];
      end
      assign shifted = overRange ? {DATA_W{signBit}} : stage[LOG_W];
    end else begin : g_operator
      assign shifted = overRange ? {DATA_W{signBit}}
                                 : DATA_W'($signed(srcWord) >>> amt);
    end
  endgenerate

  // mask of the source positions that fall off the low end
  always_comb begin
    lostMask = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (overRange || (i < int'(amt[LOG_W-1:0]))) lostMask[i] = 1'b1;
    end
  end

  assign carryNext = signBit & (|(srcWord & lostMask));

  always_comb begin
    crNext        = '0;
    crNext[CR_LT] = shifted[DATA_W-1];
    crNext[CR_GT] = ~shifted[DATA_W-1] & (|shifted);
    crNext[CR_EQ] = ~(|shifted);
    crNext[CR_SO] = soIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultWord <= '0;
      carryOut   <= 1'b0;
      crField    <= '0;
    end else begin
      if (strobes.loadRes) begin
        resultWord <= shifted;
        carryOut   <= carryNext;
      end
      if (strobes.loadCr) crField <= crNext;
    end
  end
endmodule

// File: rtl/sra_flag_unit.sv
module sra_flag_unit
  import sra_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit USE_BARREL = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] amtWord,
  input  logic              recordMode,
  input  logic              soIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultWord,
  output logic              carryOut,
  output logic [CR_W-1:0]   crField,
  output logic              crWrite
);
  ctrlStrobes_t strobes;

  sra_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .recordMode(recordMode),
    .strobes(strobes), .outValid(outValid), .crWrite(crWrite)
  );

  sra_datapath #(.DATA_W(DATA_W), .USE_BARREL(USE_BARREL)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcWord(srcWord),
    .amtWord(amtWord), .soIn(soIn), .resultWord(resultWord),
    .carryOut(carryOut), .crField(crField)
  );
endmodule

// File: rtl/sra_flag_unit_chk.sv
module sra_flag_unit_chk #(
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              recordMode,
  input logic              outValid,
  input logic [DATA_W-1:0] resultWord,
  input logic              carryOut,
  input logic [3:0]        crField,
  input logic              crWrite
);
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resultWord) && $stable(carryOut)));
  assert_cr_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && recordMode) |=> ($stable(crField) && !crWrite));
  assert_cr_write_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    crWrite |-> outValid);
  assert_cr_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    crWrite |-> ($countones(crField[3:1]) == 1));
  assert_carry_needs_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> resultWord[DATA_W-1]);
endmodule

bind sra_flag_unit sra_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .recordMode(recordMode),
  .outValid(outValid), .resultWord(resultWord), .carryOut(carryOut),
  .crField(crField), .crWrite(crWrite)
);

// File: tb/tb_sra_flag_unit.sv
module tb_sra_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 12;

  // {src, amt, record, so}
  typedef struct packed {
    logic [W-1:0] src;
    logic [W-1:0] amt;
    logic         rec;
    logic         so;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h87654321, 32'd7,          1'b1, 1'b0},
    '{32'h00000000, 32'd0,          1'b1, 1'b1},
    '{32'h7FFFFFFF, 32'd31,         1'b1, 1'b0},
    '{32'h80000000, 32'd31,         1'b0, 1'b0},
    '{32'h80000001, 32'd1,          1'b1, 1'b1},
    '{32'h12345678, 32'h00000044,   1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'd40,         1'b1, 1'b0},
    '{32'h40000000, 32'd32,         1'b1, 1'b0},
    '{32'h80000000, 32'd63,         1'b0, 1'b1},
    '{32'hC0000003, 32'hFFFFFF05,   1'b1, 1'b1},
    '{32'h00000001, 32'd1,          1'b1, 1'b0},
    '{32'h9ABCDEF0, 32'd4,          1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN;
  logic inValid, recordMode, soIn;
  logic [W-1:0] srcWord, amtWord;
  logic outValid, carryOut, crWrite;
  logic [W-1:0] resultWord;
  logic [3:0] crField;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] lastCr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sra_flag_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWord(srcWord),
    .amtWord(amtWord), .recordMode(recordMode), .soIn(soIn),
    .outValid(outValid), .resultWord(resultWord), .carryOut(carryOut),
    .crField(crField), .crWrite(crWrite)
  );

  function automatic logic [W-1:0] refShift(logic [W-1:0] s, logic [W-1:0] a);
    int n = int'(a[5:0]);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i + n < W) ? s[i+n] : s[W-1];
    return r;
  endfunction

  function automatic logic refCarry(logic [W-1:0] s, logic [W-1:0] a);
    int n = int'(a[5:0]);
    logic any = 1'b0;
    for (int j = 0; j < W; j++) if (j < n && s[j]) any = 1'b1;
    return s[W-1] & any;
  endfunction

  function automatic logic [3:0] refCr(logic [W-1:0] r, logic so);
    return {r[W-1], (!r[W-1] && r != 0), (r == 0), so};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [W-1:0] s, logic [W-1:0] a, logic rec, logic so);
    @(negedge clk);
    inValid = 1'b1; srcWord = s; amtWord = a; recordMode = rec; soIn = so;
    @(negedge clk);
    inValid = 1'b0; srcWord = ~s; amtWord = a + 1; recordMode = ~rec; soIn = ~so;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 0; srcWord = '0; amtWord = '0; recordMode = 0; soIn = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 outValid", 64'(outValid), 64'd0);
    check("R7 resultWord", 64'(resultWord), 64'd0);
    check("R7 carryOut", 64'(carryOut), 64'd0);
    check("R7 crField", 64'(crField), 64'd0);
    check("R7 crWrite", 64'(crWrite), 64'd0);
    rstN = 1'b1;
    lastCr = 4'h0;

    for (int v = 0; v < NVEC; v++) begin
      logic [W-1:0] er;
      er = refShift(VECS[v].src, VECS[v].amt);
      issue(VECS[v].src, VECS[v].amt, VECS[v].rec, VECS[v].so);
      check("R6 outValid", 64'(outValid), 64'd1);
      check("R1 R2 result", 64'(resultWord), 64'(er));
      check("R3 carry", 64'(carryOut), 64'(refCarry(VECS[v].src, VECS[v].amt)));
      if (VECS[v].rec) begin
        lastCr = refCr(er, VECS[v].so);
        check("R4 crWrite", 64'(crWrite), 64'd1);
      end else begin
        check("R5 crWrite", 64'(crWrite), 64'd0);
      end
      check("R4 R5 crField", 64'(crField), 64'(lastCr));
    end

    // R8: the worked example
    issue(32'h87654321, 32'd7, 1'b0, 1'b0);
    check("R8 result", 64'(resultWord), 64'hFF0ECA86);
    check("R8 carry", 64'(carryOut), 64'd1);

    // R6: idle cycle holds result and carry, valid drops
    @(negedge clk);
    check("R6 idle outValid", 64'(outValid), 64'd0);
    check("R6 idle result", 64'(resultWord), 64'hFF0ECA86);
    check("R6 idle carry", 64'(carryOut), 64'd1);

    // R5: non-record op after record op keeps condition field
    issue(32'h00000010, 32'd0, 1'b1, 1'b1);
    check("R4 positive cr", 64'(crField), 64'b0101);
    issue(32'hF0000000, 32'd2, 1'b0, 1'b0);
    check("R5 cr kept", 64'(crField), 64'b0101);
    check("R5 result updated", 64'(resultWord), 64'hFC000000);
    check("R5 carry updated", 64'(carryOut), 64'd0);

    // R1: upper count bits ignored (count 0 with junk above bit 5)
    issue(32'h89ABCDEF, 32'hFFFFFFC0, 1'b1, 1'b0);
    check("R1 upper bits ignored", 64'(resultWord), 64'h89ABCDEF);
    check("R3 zero count no carry", 64'(carryOut), 64'd0);
    check("R4 negative cr", 64'(crField), 64'b1000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule